// File: doc/BRIEF.md
# Three-Level Carrier PWM with Half-Link Shoot-Through

This block drives the four gates of each leg in a three-phase, three-level T-type bridge that is fed through a split impedance network. Each leg has an outer switch to the positive rail, an outer switch to the negative rail, and a bidirectional middle pair to the neutral point. The block compares offset-injected phase references against two stacked triangular carriers. A shoot-through width `boost_w` stretches one outer gate of the top or bottom phase, so that the leg shorts only one half of the DC link. This produces the boost. The whole link is never shorted.

The references, the gain `m_gain` and `boost_w` are captured only at the carrier valley. Every gate edge pair is therefore symmetric within its switching period. All outputs are registered. The single-bit `st_flag` marks the cycles in which any leg is in a half-link short.

Top module: `split_st_pwm`

## Requirements
- R1: While `rst` is high, every leg drives up_mid=1 and dn_mid=1, up_outer=0 and dn_outer=0, and `st_flag` is low.
- R2: The upper carrier counts 0,1,…,CMAX,CMAX-1,…,1 and then repeats, giving a period of 2·CMAX cycles. The lower carrier equals the upper carrier minus CMAX.
- R3: Each reference is multiplied by `m_gain`, which has M_FRAC fractional bits, and floored. Then floor((max+min)/2) of the three scaled values is subtracted from each one. The result is clamped to ±CMAX.
- R4: Per leg, with carriers cu and cd and conditioned reference v: up_outer = (rh > cu), up_mid = (cu ≥ v), dn_mid = (v > cd) and dn_outer = (cd ≥ rl). Here rh = v, except for the top phase, where rh = v+D saturated at CMAX. Likewise rl = v, except for the bottom phase, where rl = v−D saturated at −CMAX. The top phase is the largest reference and the bottom phase is the smallest; ties go to the lowest index, and phase a is bit 0. D is `boost_w` limited to CMAX.
- R5: With D=0, up_mid is the exact complement of up_outer, dn_outer is the exact complement of dn_mid, and `st_flag` stays low.
- R6: Only the top phase takes an upper short (up_outer and up_mid both on). Only the bottom phase takes a lower short (dn_outer and dn_mid both on). When neither window clips, each short lasts 2·D cycles per period.
- R7: No leg ever has up_outer and dn_outer on together, and at most one leg is in a short in any cycle.
- R8: An upper short occurs only when no leg is at P (up_outer on, up_mid off). A lower short occurs only when no leg is at N (dn_outer on, dn_mid off).
- R9: In any cycle in which an upper short is active, the bottom phase's dn_outer uses the unshifted reference, which withholds the lower short.
- R10: The references, `m_gain` and `boost_w` are sampled only when the carrier is at 0. Changes made at any other time have no effect until the next valley.
- R11: `st_flag` is high in exactly the cycles in which some leg shows an upper or lower short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | REF_W | Phase a reference, signed, on the carrier scale |
| ref_b | input | REF_W | Phase b reference, signed |
| ref_c | input | REF_W | Phase c reference, signed |
| m_gain | input | M_FRAC+1 | Unsigned gain, M_FRAC fractional bits |
| boost_w | input | CNT_W | Half-link short width D in carrier counts |
| up_outer | output | 3 | Outer switch to the positive rail, one bit per phase |
| up_mid | output | 3 | Middle switch paired with up_outer |
| dn_mid | output | 3 | Middle switch paired with dn_outer |
| dn_outer | output | 3 | Outer switch to the negative rail |
| st_flag | output | 1 | High while any leg is in a half-link short |

## Verification
A corrupted carrier counter shows up at once as a changed spacing between the narrow gate pulses that mark the valley, and that spacing is measured directly. A corrupted sampled reference or width register changes the per-period on-time of the affected gates from the next cycle until the following valley. Comparing per-period on-counts against an arithmetic model therefore exposes it within one period. Errors in envelope selection or in the block logic break the per-cycle invariants (no full short, one shorting leg, no P during an upper short, no N during a lower short) in the same cycle they occur.

// File: rtl/split_st_pwm_pkg.sv
package split_st_pwm_pkg;
  localparam int NPH   = 3;
  localparam int IDX_W = 2;

  // Gate set of one leg: s1 outer-up, s2 outer-down, s3 mid-up, s4 mid-down
  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } leg_gate_t;

  localparam leg_gate_t LEG_ZERO = '{s1: 1'b0, s2: 1'b0, s3: 1'b1, s4: 1'b1};
endpackage

// File: rtl/split_st_pwm_carrier.sv
module split_st_pwm_carrier #(
  parameter int CMAX = 100,
  localparam int CNT_W = $clog2(CMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valley_o
);
  logic rising_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == CNT_W'(CMAX - 1)) rising_q <= 1'b0;
    end else begin
      cnt_o <= cnt_o - 1'b1;
      if (cnt_o == CNT_W'(1)) rising_q <= 1'b1;
    end
  end

  assign valley_o = (cnt_o == '0);

  AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= CNT_W'(CMAX)); // R2
  AST_CARRIER_PEAK: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_W'(CMAX)) |=> (cnt_o == CNT_W'(CMAX - 1))); // R2
  AST_CARRIER_VALLEY: assert property (@(posedge clk) disable iff (rst)
    valley_o |=> (cnt_o == CNT_W'(1))); // R2
endmodule

// File: rtl/split_st_pwm_refcond.sv
module split_st_pwm_refcond
  import split_st_pwm_pkg::*;
#(
  parameter int REF_W  = 10,
  parameter int M_FRAC = 8,
  parameter int CMAX   = 100,
  localparam int CNT_W = $clog2(CMAX + 1),
  localparam int IW    = REF_W + M_FRAC + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valley,
  input  logic signed [REF_W-1:0] ref_in [NPH],
  input  logic        [M_FRAC:0]  m_gain,
  input  logic        [CNT_W-1:0] boost_w,
  output logic signed [IW-1:0]    rn_q   [NPH],
  output logic signed [IW-1:0]    rh_q   [NPH],
  output logic signed [IW-1:0]    rl_q   [NPH],
  output logic        [CNT_W-1:0] d0_q
);
  localparam logic signed [IW-1:0] CMAX_S = IW'(CMAX);

  function automatic logic signed [IW-1:0] clampv(input logic signed [IW-1:0] x);
    if (x > CMAX_S)  return CMAX_S;
    if (x < -CMAX_S) return -CMAX_S;
    return x;
  endfunction

  function automatic logic signed [IW-1:0] scale(input logic signed [REF_W-1:0] r,
                                                input logic [M_FRAC:0] g);
    logic signed [IW-1:0] er, eg;
    er = {{(IW-REF_W){r[REF_W-1]}}, r};
    eg = {{(IW-M_FRAC-1){1'b0}}, g};
    return (er * eg) >>> M_FRAC;
  endfunction

  logic signed [IW-1:0] scl [NPH];
  logic signed [IW-1:0] vo  [NPH];
  logic signed [IW-1:0] rh  [NPH];
  logic signed [IW-1:0] rl  [NPH];
  logic signed [IW-1:0] half, d0s;
  logic [IDX_W-1:0]     imx, imn;
  logic [CNT_W-1:0]     d0e;

  always_comb begin
    for (int i = 0; i < NPH; i++) scl[i] = scale(ref_in[i], m_gain);
  end

  always_comb begin
    imx = '0;
    imn = '0;
    for (int i = 1; i < NPH; i++) begin
      if (scl[i] > scl[imx]) imx = IDX_W'(i);
      if (scl[i] < scl[imn]) imn = IDX_W'(i);
    end
    half = (scl[imx] + scl[imn]) >>> 1;
    d0e  = (boost_w > CNT_W'(CMAX)) ? CNT_W'(CMAX) : boost_w;
    d0s  = IW'(d0e);
    for (int i = 0; i < NPH; i++) begin
      vo[i] = clampv(scl[i] - half);
      rh[i] = (IDX_W'(i) == imx) ? clampv(vo[i] + d0s) : vo[i];
      rl[i] = (IDX_W'(i) == imn) ? clampv(vo[i] - d0s) : vo[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPH; i++) begin
        rn_q[i] <= '0;
        rh_q[i] <= '0;
        rl_q[i] <= '0;
      end
      d0_q <= '0;
    end else if (valley) begin
      for (int i = 0; i < NPH; i++) begin
        rn_q[i] <= vo[i];
        rh_q[i] <= rh[i];
        rl_q[i] <= rl[i];
      end
      d0_q <= d0e;
    end
  end

  AST_HOLD_OFF_VALLEY: assert property (@(posedge clk) disable iff (rst)
    !valley |=> ($stable(rn_q[0]) && $stable(rn_q[1]) && $stable(rn_q[2]) && $stable(d0_q))); // R10
  AST_REF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rh_q[0] <= CMAX_S) && (rl_q[0] >= -CMAX_S) && (rn_q[0] <= CMAX_S)); // R3
endmodule

// File: rtl/split_st_pwm_leg.sv
module split_st_pwm_leg
  import split_st_pwm_pkg::*;
#(
  parameter int CMAX = 100,
  parameter int IW   = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] c_up,
  input  logic signed [IW-1:0] ref_nom,
  input  logic signed [IW-1:0] ref_hi,
  input  logic signed [IW-1:0] ref_lo,
  input  logic                 lst_block,
  output logic                 ust_req,
  output logic                 lst_req,
  output leg_gate_t            gates_q
);
  localparam logic signed [IW-1:0] CMAX_S = IW'(CMAX);

  logic signed [IW-1:0] c_dn;
  leg_gate_t nxt;

  always_comb begin
    c_dn   = c_up - CMAX_S;
    nxt.s1 = ref_hi > c_up;
    nxt.s3 = c_up >= ref_nom;
    nxt.s4 = ref_nom > c_dn;
    nxt.s2 = lst_block ? (c_dn >= ref_nom) : (c_dn >= ref_lo);
    ust_req = nxt.s1 & nxt.s3;
    lst_req = nxt.s2 & nxt.s4;
  end

  always_ff @(posedge clk) begin
    if (rst) gates_q <= LEG_ZERO;
    else     gates_q <= nxt;
  end
endmodule

// File: rtl/split_st_pwm.sv
module split_st_pwm
  import split_st_pwm_pkg::*;
#(
  parameter int REF_W  = 10,
  parameter int M_FRAC = 8,
  parameter int CMAX   = 100,
  localparam int CNT_W = $clog2(CMAX + 1),
  localparam int IW    = REF_W + M_FRAC + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic        [M_FRAC:0]  m_gain,
  input  logic        [CNT_W-1:0] boost_w,
  output logic        [NPH-1:0]   up_outer,
  output logic        [NPH-1:0]   up_mid,
  output logic        [NPH-1:0]   dn_mid,
  output logic        [NPH-1:0]   dn_outer,
  output logic                    st_flag
);
  logic [CNT_W-1:0]        cnt;
  logic                    valley;
  logic signed [REF_W-1:0] refs [NPH];
  logic signed [IW-1:0]    rn [NPH];
  logic signed [IW-1:0]    rh [NPH];
  logic signed [IW-1:0]    rl [NPH];
  logic [CNT_W-1:0]        d0_q;
  logic signed [IW-1:0]    c_up;
  logic [NPH-1:0]          ust_req, lst_req;
  logic                    lst_block;
  leg_gate_t               gq [NPH];
  logic [NPH-1:0]          st_vec;

  assign refs[0] = ref_a;
  assign refs[1] = ref_b;
  assign refs[2] = ref_c;

  split_st_pwm_carrier #(.CMAX(CMAX)) u_carrier (
    .clk(clk), .rst(rst), .cnt_o(cnt), .valley_o(valley)
  );

  split_st_pwm_refcond #(.REF_W(REF_W), .M_FRAC(M_FRAC), .CMAX(CMAX)) u_refcond (
    .clk(clk), .rst(rst), .valley(valley), .ref_in(refs), .m_gain(m_gain),
    .boost_w(boost_w), .rn_q(rn), .rh_q(rh), .rl_q(rl), .d0_q(d0_q)
  );

  assign c_up      = IW'(cnt);
  assign lst_block = |ust_req;

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    split_st_pwm_leg #(.CMAX(CMAX), .IW(IW)) u_leg (
      .clk(clk), .rst(rst), .c_up(c_up), .ref_nom(rn[i]), .ref_hi(rh[i]),
      .ref_lo(rl[i]), .lst_block(lst_block), .ust_req(ust_req[i]),
      .lst_req(lst_req[i]), .gates_q(gq[i])
    );
    assign up_outer[i] = gq[i].s1;
    assign dn_outer[i] = gq[i].s2;
    assign up_mid[i]   = gq[i].s3;
    assign dn_mid[i]   = gq[i].s4;
  end

  always_ff @(posedge clk) begin
    if (rst) st_flag <= 1'b0;
    else     st_flag <= (|ust_req) | (|lst_req);
  end

  assign st_vec = (up_outer & up_mid) | (dn_outer & dn_mid);

  AST_NO_FULL_SHORT: assert property (@(posedge clk) disable iff (rst)
    (up_outer & dn_outer) == '0); // R7
  AST_ONE_SHORT_LEG: assert property (@(posedge clk) disable iff (rst)
    $countones(st_vec) <= 1); // R7
  AST_UPPER_NO_P: assert property (@(posedge clk) disable iff (rst)
    (|(up_outer & up_mid)) |-> ((up_outer & ~up_mid) == '0)); // R8
  AST_LOWER_NO_N: assert property (@(posedge clk) disable iff (rst)
    (|(dn_outer & dn_mid)) |-> ((dn_outer & ~dn_mid) == '0)); // R8
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    st_flag == (|st_vec)); // R11
  AST_ZERO_WIDTH_COMPL: assert property (@(posedge clk) disable iff (rst)
    (d0_q == '0) |=> ((up_mid == ~up_outer) && (dn_outer == ~dn_mid))); // R5
endmodule

// File: tb/split_st_pwm_tb.sv
module split_st_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_W  = 10;
  localparam int M_FRAC = 8;
  localparam int CMAX   = 100;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int PER    = 2 * CMAX;
  localparam int WDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [M_FRAC:0]  m_gain  = '0;
  logic [CNT_W-1:0] boost_w = '0;
  logic [2:0] up_outer, up_mid, dn_mid, dn_outer;
  logic st_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int e_cnt [3][4];
  int e_ust [3];
  int e_lst [3];
  int m_cnt [3][4];
  int m_ust [3];
  int m_lst [3];
  int v_full, v_multi, v_ustp, v_lstn, v_flag, v_comp, n_flag;

  split_st_pwm #(.REF_W(REF_W), .M_FRAC(M_FRAC), .CMAX(CMAX)) u_dut (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .m_gain(m_gain), .boost_w(boost_w), .up_outer(up_outer), .up_mid(up_mid),
    .dn_mid(dn_mid), .dn_outer(dn_outer), .st_flag(st_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c, input int m, input int d);
    @(negedge clk);
    ref_a = REF_W'(a); ref_b = REF_W'(b); ref_c = REF_W'(c);
    m_gain = (M_FRAC + 1)'(m);
    boost_w = CNT_W'(d);
    repeat (2 * PER + 4) @(negedge clk);
  endtask

  // Expected behaviour from R3, R4, R9
  task automatic build_expect(input int a, input int b, input int c, input int m, input int d);
    int s [3]; int v [3]; int r1 [3]; int r2 [3];
    int imx, imn, h, dd;
    s[0] = (a * m) >>> M_FRAC;
    s[1] = (b * m) >>> M_FRAC;
    s[2] = (c * m) >>> M_FRAC;
    imx = 0; imn = 0;
    for (int i = 1; i < 3; i++) begin
      if (s[i] > s[imx]) imx = i;
      if (s[i] < s[imn]) imn = i;
    end
    h = (s[imx] + s[imn]) >>> 1;
    dd = (d > CMAX) ? CMAX : d;
    for (int i = 0; i < 3; i++) begin
      v[i] = s[i] - h;
      if (v[i] > CMAX) v[i] = CMAX;
      if (v[i] < -CMAX) v[i] = -CMAX;
      r1[i] = v[i]; r2[i] = v[i];
    end
    r1[imx] = (v[imx] + dd > CMAX) ? CMAX : v[imx] + dd;
    r2[imn] = (v[imn] - dd < -CMAX) ? -CMAX : v[imn] - dd;
    for (int i = 0; i < 3; i++) begin
      e_ust[i] = 0; e_lst[i] = 0;
      for (int g = 0; g < 4; g++) e_cnt[i][g] = 0;
    end
    for (int k = 0; k < PER; k++) begin
      int cu, cd;
      bit blk;
      bit g1 [3]; bit g2 [3]; bit g3 [3]; bit g4 [3];
      cu = (k <= CMAX) ? k : PER - k;
      cd = cu - CMAX;
      blk = 1'b0;
      for (int i = 0; i < 3; i++) begin
        g1[i] = r1[i] > cu;
        g3[i] = cu >= v[i];
        g4[i] = v[i] > cd;
        if (g1[i] && g3[i]) blk = 1'b1;
      end
      for (int i = 0; i < 3; i++) begin
        g2[i] = blk ? (cd >= v[i]) : (cd >= r2[i]);
        e_cnt[i][0] += int'(g1[i]);
        e_cnt[i][1] += int'(g3[i]);
        e_cnt[i][2] += int'(g4[i]);
        e_cnt[i][3] += int'(g2[i]);
        e_ust[i] += int'(g1[i] && g3[i]);
        e_lst[i] += int'(g2[i] && g4[i]);
      end
    end
  endtask

  task automatic measure();
    v_full = 0; v_multi = 0; v_ustp = 0; v_lstn = 0; v_flag = 0; v_comp = 0; n_flag = 0;
    for (int i = 0; i < 3; i++) begin
      m_ust[i] = 0; m_lst[i] = 0;
      for (int g = 0; g < 4; g++) m_cnt[i][g] = 0;
    end
    for (int k = 0; k < PER; k++) begin
      logic [2:0] us, ls;
      @(negedge clk);
      us = up_outer & up_mid;
      ls = dn_outer & dn_mid;
      for (int i = 0; i < 3; i++) begin
        m_cnt[i][0] += int'(up_outer[i]);
        m_cnt[i][1] += int'(up_mid[i]);
        m_cnt[i][2] += int'(dn_mid[i]);
        m_cnt[i][3] += int'(dn_outer[i]);
        m_ust[i] += int'(us[i]);
        m_lst[i] += int'(ls[i]);
      end
      if ((up_outer & dn_outer) != 3'b000) v_full++;
      if ($countones(us | ls) > 1) v_multi++;
      if ((us != 3'b000) && ((up_outer & ~up_mid) != 3'b000)) v_ustp++;
      if ((ls != 3'b000) && ((dn_outer & ~dn_mid) != 3'b000)) v_lstn++;
      if (st_flag != ((us | ls) != 3'b000)) v_flag++;
      if ((up_mid != ~up_outer) || (dn_outer != ~dn_mid)) v_comp++;
      n_flag += int'(st_flag);
    end
  endtask

  task automatic compare(input string gtag, input string stag);
    for (int i = 0; i < 3; i++) begin
      chk(gtag, $sformatf("phase %0d up_outer on-count", i), m_cnt[i][0], e_cnt[i][0]);
      chk(gtag, $sformatf("phase %0d up_mid on-count", i), m_cnt[i][1], e_cnt[i][1]);
      chk(gtag, $sformatf("phase %0d dn_mid on-count", i), m_cnt[i][2], e_cnt[i][2]);
      chk(gtag, $sformatf("phase %0d dn_outer on-count", i), m_cnt[i][3], e_cnt[i][3]);
      chk(stag, $sformatf("phase %0d upper-short cycles", i), m_ust[i], e_ust[i]);
      chk(stag, $sformatf("phase %0d lower-short cycles", i), m_lst[i], e_lst[i]);
    end
    chk("R7", "cycles with full short", v_full, 0);
    chk("R7", "cycles with several shorting legs", v_multi, 0);
    chk("R8", "upper short while a leg at P", v_ustp, 0);
    chk("R8", "lower short while a leg at N", v_lstn, 0);
    chk("R11", "flag mismatch cycles", v_flag, 0);
  endtask

  task automatic run_case(input int a, input int b, input int c, input int m, input int d,
                          input string gtag, input string stag);
    apply(a, b, c, m, d);
    build_expect(a, b, c, m, d);
    measure();
    compare(gtag, stag);
  endtask

  task automatic t_reset();
    ref_a = 10'sd50; ref_b = -10'sd20; m_gain = 9'd256; boost_w = 7'd10;
    repeat (5) @(negedge clk);
    chk("R1", "up_outer in reset", int'(up_outer), 0);
    chk("R1", "dn_outer in reset", int'(dn_outer), 0);
    chk("R1", "up_mid in reset", int'(up_mid), 7);
    chk("R1", "dn_mid in reset", int'(dn_mid), 7);
    chk("R1", "st_flag in reset", int'(st_flag), 0);
    rst = 1'b0;
  endtask

  task automatic t_no_boost();
    run_case(40, -10, -30, 256, 0, "R4", "R5");
    chk("R5", "complement violations", v_comp, 0);
    chk("R5", "flag-high cycles", n_flag, 0);
  endtask

  task automatic t_boost();
    run_case(40, -10, -30, 256, 10, "R4", "R6");
    chk("R6", "top phase a upper-short cycles", m_ust[0], 20);
    chk("R6", "bottom phase c lower-short cycles", m_lst[2], 20);
    chk("R6", "shorts on other legs", m_ust[1] + m_ust[2] + m_lst[0] + m_lst[1], 0);
  endtask

  task automatic t_scale();
    run_case(90, -60, 20, 128, 8, "R3", "R6");
  endtask

  task automatic t_clamp();
    run_case(300, -300, 0, 256, 20, "R3", "R4");
    chk("R4", "saturated top phase upper short", m_ust[0], 0);
    chk("R4", "saturated top phase up_outer", m_cnt[0][0], PER - 1);
  endtask

  task automatic t_overlap();
    run_case(0, 0, 0, 256, 60, "R4", "R9");
    chk("R9", "upper-short cycles on phase a", m_ust[0], 119);
    chk("R9", "withheld lower-short cycles on phase a", m_lst[0], 80);
  endtask

  task automatic t_sample();
    int found, nz, last;
    apply(1, -1, 0, 256, 0);
    found = 0;
    for (int k = 0; k < PER + 2 && found == 0; k++) begin
      @(negedge clk);
      if (up_outer[0]) found = 1;
    end
    chk("R2", "valley marker pulse seen", found, 1);
    nz = 0; last = 0;
    for (int j = 1; j <= PER; j++) begin
      @(negedge clk);
      if (j < PER) nz += int'(up_outer[0]);
      else last = int'(up_outer[0]);
      if (j == CMAX) ref_a = 10'sd60;
    end
    chk("R10", "up_outer pulses after mid-period change", nz, 0);
    chk("R2", "marker recurs after 2*CMAX cycles", last, 1);
  endtask

  initial begin
    t_reset();
    t_no_boost();
    t_boost();
    t_scale();
    t_clamp();
    t_overlap();
    t_sample();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule